// File: doc/BRIEF.md
# Configurable Port Controller with Shared Peripheral Outputs

This block controls a parameterizable group of general-purpose pad bits (eight by default). Each bit is set up by three configuration registers that together pick a three-bit mode. The mode can make the bit an input with or without pull-up, a push-pull or open-drain output, a bidirectional bit with a weak pull-up, an open-drain or push-pull pin driven by peripherals, or an analog pin. A CPU writes the output data and the configuration through a small register interface. Output data goes first into a master latch. A slave latch then copies it and drives the pad.

Several peripherals can offer an output for every bit. Each peripheral's vector is gated by its enable, so a disabled peripheral presents logic 1. The enabled vectors are then combined by a bitwise AND. A per-bit analog flag forces the combined peripheral value high. The pad input passes through a two-flop synchroniser. The synchronised value always goes to the CPU read path, in every mode. It also goes to the peripheral input fan-out, and when a bit drives a peripheral value, that value loops back onto this fan-out. A low-power request freezes the register state.

Top module: `gpio_afport`

## Requirements
- R1: After reset every bit is in mode 100 (bidirectional, weak pull-up) and the data latches hold all ones, so pad_oe is 0, pad_do is 1 and pad_pu is 1 (when pu_hw_dis is 0).
- R2: The mode is {cfg2,cfg1,cfg0} per bit. Pull-up is on only in modes 000 and 100. pad_oe is 0 in modes 000, 001 and 111, and 1 in modes 010 and 101. pad_do carries the slave latch value, except in modes 101 and 110, where it carries the combined peripheral value.
- R3: In open-drain style modes (011 and 100 on the latch value, 110 on the peripheral value), pad_oe is 1 only when the driven value is 0.
- R4: A data write (wr_sel 0) loads the master latch at the write edge. The pad value changes at the next clock edge.
- R5: A configuration write (wr_sel 1, 2, 3 selecting cfg0, cfg1, cfg2) takes effect on the pad controls right after the write edge.
- R6: The peripheral value of a bit is the AND, over all peripherals, of (af_en[p] ? af_out[p*WIDTH+i] : 1).
- R7: A bit with analog_sel set has its peripheral value forced to 1.
- R8: din_sync equals pad_in as sampled two clock edges earlier, whatever the mode.
- R9: af_in equals din_sync, except in modes 101 and 110, where it is din_sync ANDed with the bit's driven peripheral value.
- R10: While pu_hw_dis is 1, pad_pu is 0 for every bit.
- R11: While lp_mode is 1, CPU writes are ignored and the data and configuration state stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 cfg0, 2 cfg1, 3 cfg2 |
| wr_val | input | WIDTH | Write data |
| lp_mode | input | 1 | Wait/halt low-power request; freezes state |
| af_out | input | NUM_AF*WIDTH | Peripheral output vectors, peripheral p at bits p*WIDTH upward |
| af_en | input | NUM_AF | Peripheral output enables |
| analog_sel | input | WIDTH | Per-bit analog assignment |
| pu_hw_dis | input | 1 | Hardware pull-up disable |
| pad_in | input | WIDTH | Pad input level |
| pad_oe | output | WIDTH | Pad output enable |
| pad_do | output | WIDTH | Pad output value |
| pad_pu | output | WIDTH | Weak pull-up enable |
| din_sync | output | WIDTH | Synchronised input for the CPU read path |
| af_in | output | WIDTH | Input fanned out to the peripherals |

## Verification
The mode decoder is driven with random configuration words, so all eight modes appear across the bits at the same time. This separates a per-bit decode from a whole-port decode, and it shows when one mode's drive rules leak into another. The peripheral AND is tried with random enables and with directed cases where only one peripheral pulls a bit low. This tells a correct AND-with-gating apart from an OR or from ungated inputs. Analog forcing, loopback with an external level that disagrees, hardware pull-up disable, and writes during low power are each tested directly. The two-stage data latch is probed on the cycle between the write edge and the pad update, which separates a one-edge path from a two-edge path.

// File: rtl/gpio_afport_pkg.sv
package gpio_afport_pkg;
  typedef enum logic [2:0] {
    PM_IN_PU  = 3'b000,
    PM_IN_HZ  = 3'b001,
    PM_OUT_PP = 3'b010,
    PM_OUT_OD = 3'b011,
    PM_BIDIR  = 3'b100,
    PM_AF_PP  = 3'b101,
    PM_AF_OD  = 3'b110,
    PM_ANALOG = 3'b111
  } pad_mode_e;

  typedef enum logic [1:0] {
    WS_DATA = 2'd0,
    WS_CFG0 = 2'd1,
    WS_CFG1 = 2'd2,
    WS_CFG2 = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic oe;
    logic dout;
    logic pu;
  } pad_drv_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_afport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_val,
  input  logic         lp_mode,
  output logic [W-1:0] master_q,
  output logic [W-1:0] slave_q,
  output logic [W-1:0] cfg0_q,
  output logic [W-1:0] cfg1_q,
  output logic [W-1:0] cfg2_q
);
  logic [W-1:0] master_d, cfg0_d, cfg1_d, cfg2_d;
  logic         wr_ok;
  logic         slave_en;

  // next-state
  always_comb begin
    master_d = master_q;
    cfg0_d   = cfg0_q;
    cfg1_d   = cfg1_q;
    cfg2_d   = cfg2_q;
    wr_ok    = wr_en & ~lp_mode;
    if (wr_ok) begin
      case (wr_sel_e'(wr_sel))
        WS_DATA: master_d = wr_val;
        WS_CFG0: cfg0_d   = wr_val;
        WS_CFG1: cfg1_d   = wr_val;
        WS_CFG2: cfg2_d   = wr_val;
        default: master_d = master_q;
      endcase
    end
    slave_en = (slave_q != master_q);
  end

  // registers; reset gives mode 100 and all-ones data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '1;
      slave_q  <= '1;
      cfg0_q   <= '0;
      cfg1_q   <= '0;
      cfg2_q   <= '1;
    end else begin
      master_q <= master_d;
      cfg0_q   <= cfg0_d;
      cfg1_q   <= cfg1_d;
      cfg2_q   <= cfg2_d;
      if (slave_en) slave_q <= master_q;
    end
  end
endmodule

// File: rtl/gpio_af_combine.sv
module gpio_af_combine #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic [N*W-1:0] af_out,
  input  logic [N-1:0]   af_en,
  input  logic [W-1:0]   analog_sel,
  output logic [W-1:0]   af_val
);
  logic [W-1:0] gated [N];
  logic [W-1:0] chain [N+1];

  assign chain[0] = '1;

  for (genvar p = 0; p < N; p++) begin : g_per
    // a disabled peripheral contributes ones
    assign gated[p]   = af_en[p] ? af_out[p*W +: W] : '1;
    assign chain[p+1] = chain[p] & gated[p];
  end

  assign af_val = chain[N] | analog_sel;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_afport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cfg0,
  input  logic [W-1:0] cfg1,
  input  logic [W-1:0] cfg2,
  input  logic [W-1:0] slave,
  input  logic [W-1:0] af_val,
  input  logic [W-1:0] sync_in,
  input  logic         pu_hw_dis,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] af_in
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    pad_mode_e mode;
    pad_drv_t  drv;
    logic      is_af;

    always_comb begin
      mode  = pad_mode_e'({cfg2[i], cfg1[i], cfg0[i]});
      drv   = '{oe: 1'b0, dout: slave[i], pu: 1'b0};
      is_af = 1'b0;
      case (mode)
        PM_IN_PU:  drv.pu = 1'b1;
        PM_IN_HZ:  drv.pu = 1'b0;
        PM_OUT_PP: drv.oe = 1'b1;
        PM_OUT_OD: drv.oe = ~slave[i];
        PM_BIDIR: begin
          drv.oe = ~slave[i];
          drv.pu = 1'b1;
        end
        PM_AF_PP: begin
          drv.oe   = 1'b1;
          drv.dout = af_val[i];
          is_af    = 1'b1;
        end
        PM_AF_OD: begin
          drv.oe   = ~af_val[i];
          drv.dout = af_val[i];
          is_af    = 1'b1;
        end
        PM_ANALOG: drv.oe = 1'b0;
        default:   drv.oe = 1'b0;
      endcase
      if (pu_hw_dis) drv.pu = 1'b0;
    end

    assign pad_oe[i] = drv.oe;
    assign pad_do[i] = drv.dout;
    assign pad_pu[i] = drv.pu;
    // driven peripheral value always loops back to the peripheral inputs
    assign af_in[i]  = sync_in[i] & (is_af ? af_val[i] : 1'b1);
  end
endmodule

// File: rtl/gpio_afport.sv
module gpio_afport #(
  parameter int WIDTH  = 8,
  parameter int NUM_AF = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [WIDTH-1:0]        wr_val,
  input  logic                    lp_mode,
  input  logic [NUM_AF*WIDTH-1:0] af_out,
  input  logic [NUM_AF-1:0]       af_en,
  input  logic [WIDTH-1:0]        analog_sel,
  input  logic                    pu_hw_dis,
  input  logic [WIDTH-1:0]        pad_in,
  output logic [WIDTH-1:0]        pad_oe,
  output logic [WIDTH-1:0]        pad_do,
  output logic [WIDTH-1:0]        pad_pu,
  output logic [WIDTH-1:0]        din_sync,
  output logic [WIDTH-1:0]        af_in
);
  logic [WIDTH-1:0] master_q, slave_q, cfg0_q, cfg1_q, cfg2_q;
  logic [WIDTH-1:0] af_val;

  gpio_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_val(wr_val), .lp_mode(lp_mode), .master_q(master_q),
    .slave_q(slave_q), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q)
  );

  gpio_af_combine #(.W(WIDTH), .N(NUM_AF)) u_comb (
    .af_out(af_out), .af_en(af_en), .analog_sel(analog_sel), .af_val(af_val)
  );

  gpio_in_sync #(.W(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync)
  );

  gpio_pad_ctl #(.W(WIDTH)) u_pad (
    .cfg0(cfg0_q), .cfg1(cfg1_q), .cfg2(cfg2_q), .slave(slave_q),
    .af_val(af_val), .sync_in(din_sync), .pu_hw_dis(pu_hw_dis),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .af_in(af_in)
  );
endmodule

// File: rtl/gpio_afport_chk.sv
module gpio_afport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lp_mode,
  input logic         pu_hw_dis,
  input logic [W-1:0] analog_sel,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_do,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] din_sync,
  input logic [W-1:0] master_q,
  input logic [W-1:0] slave_q,
  input logic [W-1:0] cfg0_q,
  input logic [W-1:0] cfg1_q,
  input logic [W-1:0] cfg2_q
);
  logic [1:0]   cyc;
  logic [W-1:0] od_mask, afpp_mask, must1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assign od_mask   = (~cfg2_q & cfg1_q & cfg0_q) | (cfg2_q & cfg1_q & ~cfg0_q)
                   | (cfg2_q & ~cfg1_q & ~cfg0_q);
  assign afpp_mask = cfg2_q & ~cfg1_q & cfg0_q;
  assign must1     = analog_sel & afpp_mask;

  p_od_no_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & od_mask & pad_do) == '0);

  p_slave_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0) |-> (slave_q == $past(master_q)));

  p_analog_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_do & must1) == must1);

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (din_sync == $past(pad_in, 2)));

  p_pu_forced_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pu_hw_dis |-> (pad_pu == '0));

  p_lp_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode |=> ($stable(master_q) && $stable(cfg0_q) && $stable(cfg1_q)
                 && $stable(cfg2_q)));
endmodule

bind gpio_afport gpio_afport_chk #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .pu_hw_dis(pu_hw_dis),
  .analog_sel(analog_sel), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
  .pad_pu(pad_pu), .din_sync(din_sync), .master_q(master_q), .slave_q(slave_q),
  .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q)
);

// File: tb/sim_gpio_afport.sv
`timescale 1ns/1ps
module sim_gpio_afport;
  localparam int W = 8;
  localparam int N = 3;

  logic         clk, rst_n, wr_en, lp_mode, pu_hw_dis;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_val, analog_sel, pad_in;
  logic [N*W-1:0] af_out;
  logic [N-1:0] af_en;
  logic [W-1:0] pad_oe, pad_do, pad_pu, din_sync, af_in;

  int total, bad;
  bit done;

  // bench model of the register state
  logic [W-1:0] m_dat, m_c0, m_c1, m_c2;

  gpio_afport #(.WIDTH(W), .NUM_AF(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .lp_mode(lp_mode), .af_out(af_out), .af_en(af_en), .analog_sel(analog_sel),
    .pu_hw_dis(pu_hw_dis), .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do),
    .pad_pu(pad_pu), .din_sync(din_sync), .af_in(af_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] exp_afv();
    logic [W-1:0] v = '1;
    for (int p = 0; p < N; p++) if (af_en[p]) v &= af_out[p*W +: W];
    return v | analog_sel;
  endfunction

  // returns {oe, do, pu} for one bit
  function automatic logic [2:0] exp_bit(input logic [2:0] m, input logic s,
                                         input logic a, input logic hd);
    logic oe, dv, pu;
    oe = 1'b0; dv = s; pu = 1'b0;
    case (m)
      3'b000: pu = 1'b1;
      3'b010: oe = 1'b1;
      3'b011: oe = ~s;
      3'b100: begin oe = ~s; pu = 1'b1; end
      3'b101: begin oe = 1'b1; dv = a; end
      3'b110: begin oe = ~a; dv = a; end
      default: oe = 1'b0;
    endcase
    if (hd) pu = 1'b0;
    return {oe, dv, pu};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [W-1:0] a, e_oe, e_do, e_pu, e_ai;
    a = exp_afv();
    for (int i = 0; i < W; i++) begin
      logic [2:0] m, r;
      m = {m_c2[i], m_c1[i], m_c0[i]};
      r = exp_bit(m, m_dat[i], a[i], pu_hw_dis);
      e_oe[i] = r[2]; e_do[i] = r[1]; e_pu[i] = r[0];
      e_ai[i] = pad_in[i] & ((m == 3'b101 || m == 3'b110) ? a[i] : 1'b1);
    end
    chk({"R2/R3 oe ", tag}, pad_oe, e_oe);
    chk({"R2/R6 do ", tag}, pad_do, e_do);
    chk({"R2/R10 pu ", tag}, pad_pu, e_pu);
    chk({"R8 din ", tag}, din_sync, pad_in);
    chk({"R9 afin ", tag}, af_in, e_ai);
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_val = v;
    if (!lp_mode) begin
      case (s)
        2'd0: m_dat = v;
        2'd1: m_c0 = v;
        2'd2: m_c1 = v;
        default: m_c2 = v;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    total = 0; bad = 0; done = 1'b0;
    unused_seed = $urandom(32'h5EED1234);
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_val = '0; lp_mode = 1'b0;
    af_out = '1; af_en = '0; analog_sel = '0; pu_hw_dis = 1'b0; pad_in = 8'hC3;
    m_dat = '1; m_c0 = '0; m_c1 = '0; m_c2 = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 do", pad_do, 8'hFF);
    chk("R1 pu", pad_pu, 8'hFF);
    rst_n = 1'b1;
    settle();
    check_all("after reset");

    // R5: config write visible right after its edge (100 -> 010 push-pull)
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_val = 8'hFF; m_c1 = 8'hFF;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    wr(2'd3, 8'h00);
    chk("R5 cfg one edge oe", pad_oe, 8'hFF);

    // R4: data write lands one edge after the master
    wr(2'd0, 8'h5A);
    chk("R4 pad before slave", pad_do, 8'hFF);
    @(posedge clk); @(negedge clk);
    chk("R4 pad after slave", pad_do, 8'h5A);

    // R6: peripheral AND with gating, all bits push-pull peripheral mode
    wr(2'd3, 8'hFF); wr(2'd2, 8'h00); wr(2'd1, 8'hFF);
    af_out = {8'hF0, 8'h00, 8'h3C}; af_en = 3'b101;
    #0.5 chk("R6 and gated", pad_do, 8'h30);
    af_en = 3'b000;
    #0.5 chk("R6 all disabled", pad_do, 8'hFF);
    af_en = 3'b010;
    #0.5 chk("R6 single low", pad_do, 8'h00);
    // R7: analog forcing
    analog_sel = 8'h0F;
    #0.5 chk("R7 analog forced", pad_do, 8'h0F);
    analog_sel = '0;

    // R9/R8: loopback in peripheral open-drain mode, outside level high
    wr(2'd1, 8'h00); wr(2'd2, 8'hFF);
    af_en = 3'b001; af_out = {8'hFF, 8'hFF, 8'hA5}; pad_in = 8'hFF;
    settle();
    chk("R9 loopback", af_in, 8'hA5);
    chk("R8 din unaffected", din_sync, 8'hFF);
    chk("R3 od oe", pad_oe, 8'h5A);

    // R10: hardware pull-up disable in mode 000
    wr(2'd3, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    chk("R10 pu on", pad_pu, 8'hFF);
    pu_hw_dis = 1'b1;
    #0.5 chk("R10 pu forced off", pad_pu, 8'h00);
    pu_hw_dis = 1'b0;

    // R11: writes ignored during low-power
    @(negedge clk); lp_mode = 1'b1;
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);
    @(negedge clk); lp_mode = 1'b0;
    settle();
    chk("R11 oe frozen", pad_oe, 8'h00);
    chk("R11 pu frozen", pad_pu, 8'hFF);
    wr(2'd2, 8'hFF);
    settle();
    chk("R11 data frozen", pad_do, 8'h5A);

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic lp;
      lp = (($urandom % 6) == 0);
      @(negedge clk); lp_mode = lp;
      wr(2'($urandom % 4), W'($urandom));
      @(negedge clk); lp_mode = 1'b0;
      af_out = N*W'({$urandom, $urandom});
      af_en = N'($urandom);
      analog_sel = (($urandom % 3) == 0) ? W'($urandom) : '0;
      pu_hw_dis = (($urandom % 5) == 0);
      pad_in = W'($urandom);
      settle();
      check_all(lp ? "random lp R11" : "random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule